// File: doc/BRIEF.md
# Clock-Enabled 4096 x 1 Dynamic Memory Model

This block is a synthesizable, cycle-based functional model of a 4096-word by 1-bit dynamic memory. The cells are arranged as 64 rows of 64 columns. Every input is sampled on the system clock. A separate active-high chip enable `ce` plays the part of the memory's own strobe. When `ce` is seen rising, the block captures the address and the active-low select `cs_n` and holds them until `ce` falls. While `ce` is low the memory is in standby and nothing is read or written.

A cycle that begins with `we_n` high is a read. The stored bit comes out inverted on `dout`, and `dout_en` marks it valid; this flag stands in for a tri-state driver. Pulling `we_n` low later in the same `ce`-high period turns the read into a read-modify-write. A cycle that begins with `we_n` low is a plain write. The row is set by address bits 5:0 and the column by bits 11:6.

Any access refreshes its whole row, whether or not the chip is selected. The block keeps an age counter for each row, counted in clock ticks. A selected read of a row whose retention window has run out raises a one-cycle `stale_rd` pulse.

Top module: `dram4k_model`

## Requirements
- R1: While reset is held and in the first cycle after it, `dout_en`, `dout` and `stale_rd` are 0. `dout` is 0 in every cycle in which `dout_en` is 0.
- R2: While `ce` is low, no cell changes, whatever `we_n`, `cs_n`, `din` and `addr` do.
- R3: The address sampled in the clock where `ce` is first seen high selects the cell for the whole cycle. Later changes on `addr` have no effect until `ce` has gone low.
- R4: `cs_n` is sampled at the same clock as the address. If it was high, the cycle neither writes nor drives `dout_en`, even when `cs_n` falls later. If it was low, the cycle proceeds even when `cs_n` rises later.
- R5: In a read (selected, and `we_n` high in the clock after the `ce` rise), `dout_en` becomes 1 after that clock. `dout` equals the complement of the stored bit. Both hold while `ce` stays high, and `dout_en` returns to 0 after the first clock that samples `ce` low.
- R6: A selected cycle writes `din` into the captured cell in every clock after the rise clock in which `ce` is high and `we_n` is low. `din` has no effect while `we_n` is high.
- R7: Reading a cell after writing bit b returns the complement of b on `dout`.
- R8: A cycle that has `we_n` low in the clock after the `ce` rise is a write cycle, and `dout_en` stays 0 throughout it.
- R9: In a read-modify-write, `dout` keeps the value read at the start while `we_n` goes low and the new bit is written. A later read returns the complement of the new bit.
- R10: Every `ce` rise refreshes the row given by `addr[5:0]` and restarts its age, whether `cs_n` is high or low.
- R11: `stale_rd` pulses for exactly one clock, in the first clock where `dout_en` is 1, when a selected read starts more than RETAIN_TICKS clocks after the previous `ce` rise on the same row. Write cycles and deselected cycles never raise it.
- R12: Accessing one row does not change the age of any other row. Row 8 expires while row 7 is being refreshed.
- R13: Reset restarts the age of every row. It does not clear the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Chip enable; its rise starts an access, while low the part is in standby |
| cs_n | input | 1 | Active-low chip select, captured at the `ce` rise |
| we_n | input | 1 | Low writes, high reads |
| addr | input | 12 | Cell address; bits 5:0 row, bits 11:6 column |
| din | input | 1 | Write data |
| dout | output | 1 | Inverted read data, 0 when not enabled |
| dout_en | output | 1 | Read data valid (stands in for output drive) |
| stale_rd | output | 1 | One-clock pulse: selected read of an expired row |

## Verification
A wrong captured address or select shows up one clock after the `ce` rise. The complement of the wrong cell appears on `dout`, or `dout_en` has the wrong value. A write that should have been blocked shows only on the next read of that cell. The bench therefore follows every ignored-stimulus case with a read. A row age that was not cleared, or was cleared for the wrong row, shows up only when that row is next read: `stale_rd` is raised or missing in the first output clock, tens of cycles after the fault.

// File: rtl/dram4k_pkg.sv
package dram4k_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_READ  = 2'd2,
    PH_WRITE = 2'd3
  } phase_t;

endpackage

// File: rtl/dram4k_array.sv
module dram4k_array #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wdata,
  output logic              rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    if (rd_en) rdata <= mem[addr];
  end

  // read and write strobes never coincide (read-modify-write orders them)
  p_rd_wr_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));

  // a read fetches once per access
  p_single_fetch_r5: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);

endmodule

// File: rtl/dram4k_age.sv
module dram4k_age #(
  parameter int ROWS         = 64,
  parameter int RETAIN_TICKS = 2000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     touch,
  input  logic [$clog2(ROWS)-1:0]  touch_row,
  output logic                     row_expired
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(RETAIN_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RETAIN_TICKS);

  logic [CW-1:0] age_q [ROWS];

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (rst)
        age_q[r] <= '0;
      else if (touch && touch_row == RW'(r))
        age_q[r] <= '0;
      else if (age_q[r] != LIMIT)
        age_q[r] <= age_q[r] + 1'b1;
    end
  end

  assign row_expired = (age_q[touch_row] == LIMIT);

  generate
    for (genvar g = 0; g < ROWS; g++) begin : g_row_chk
      // any touch of a row restarts that row's age (R10)
      p_row_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (touch && touch_row == RW'(g)) |=> (age_q[g] == '0));
      // an untouched row only ages (R12)
      p_row_monotonic_r12: assert property (@(posedge clk) disable iff (rst)
        (!(touch && touch_row == RW'(g)) && age_q[g] != LIMIT)
          |=> (age_q[g] == $past(age_q[g]) + 1'b1));
    end
  endgenerate

endmodule

// File: rtl/dram4k_ctl.sv
module dram4k_ctl
  import dram4k_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int ROW_BITS = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ce,
  input  logic                cs_n,
  input  logic                we_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                row_expired,
  output logic                touch,
  output logic [ROW_BITS-1:0] touch_row,
  output logic [ADDR_W-1:0]   addr_lat,
  output logic                rd_en,
  output logic                wr_en,
  output logic                out_en,
  output logic                stale
);
  phase_t phase_q;
  logic   ce_q;
  logic   cs_lat;
  logic   exp_lat;
  logic   rise;

  assign rise      = ce && !ce_q;
  assign touch     = rise;
  assign touch_row = addr[ROW_BITS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q     <= 1'b0;
      phase_q  <= PH_IDLE;
      cs_lat   <= 1'b1;
      exp_lat  <= 1'b0;
      addr_lat <= '0;
      out_en   <= 1'b0;
      stale    <= 1'b0;
    end else begin
      ce_q  <= ce;
      stale <= 1'b0;
      if (!ce) begin
        phase_q <= PH_IDLE;
        out_en  <= 1'b0;
      end else begin
        case (phase_q)
          PH_IDLE: begin
            if (rise) begin
              addr_lat <= addr;
              cs_lat   <= cs_n;
              exp_lat  <= row_expired;
              phase_q  <= PH_FETCH;
            end
          end
          PH_FETCH: begin
            if (we_n) begin
              phase_q <= PH_READ;
              out_en  <= !cs_lat;
              stale   <= !cs_lat && exp_lat;
            end else begin
              phase_q <= PH_WRITE;
            end
          end
          default: phase_q <= phase_q;
        endcase
      end
    end
  end

  assign rd_en = ce && !cs_lat && we_n && (phase_q == PH_FETCH);
  assign wr_en = ce && !cs_lat && !we_n && (phase_q != PH_IDLE);

  // captured address holds for the whole access (R3)
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE) |=> $stable(addr_lat));

  // output drive ends the clock after ce is sampled low (R5)
  p_out_off_r5: assert property (@(posedge clk) disable iff (rst)
    !ce |=> !out_en);

  // output only turns on after a fetch with we_n high (R8)
  p_out_after_fetch_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(out_en) |-> $past(rd_en));

  // stale flag is a single pulse (R11)
  p_stale_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    stale |=> !stale);

  // stale flag only accompanies driven read data (R11)
  p_stale_with_out_r11: assert property (@(posedge clk) disable iff (rst)
    stale |-> out_en);

endmodule

// File: rtl/dram4k_model.sv
module dram4k_model #(
  parameter int ROW_BITS     = 6,
  parameter int COL_BITS     = 6,
  parameter int RETAIN_TICKS = 2000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ce,
  input  logic                         cs_n,
  input  logic                         we_n,
  input  logic [ROW_BITS+COL_BITS-1:0] addr,
  input  logic                         din,
  output logic                         dout,
  output logic                         dout_en,
  output logic                         stale_rd
);
  localparam int ADDR_W = ROW_BITS + COL_BITS;
  localparam int ROWS   = 1 << ROW_BITS;

  logic                touch;
  logic [ROW_BITS-1:0] touch_row;
  logic                row_expired;
  logic [ADDR_W-1:0]   addr_lat;
  logic                rd_en;
  logic                wr_en;
  logic                out_en;
  logic                stale;
  logic                rdata;

  dram4k_ctl #(.ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS)) u_ctl (
    .clk(clk), .rst(rst), .ce(ce), .cs_n(cs_n), .we_n(we_n), .addr(addr),
    .row_expired(row_expired), .touch(touch), .touch_row(touch_row),
    .addr_lat(addr_lat), .rd_en(rd_en), .wr_en(wr_en),
    .out_en(out_en), .stale(stale)
  );

  dram4k_age #(.ROWS(ROWS), .RETAIN_TICKS(RETAIN_TICKS)) u_age (
    .clk(clk), .rst(rst), .touch(touch), .touch_row(touch_row),
    .row_expired(row_expired)
  );

  dram4k_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr_lat), .wdata(din), .rdata(rdata)
  );

  assign dout     = out_en & ~rdata;
  assign dout_en  = out_en;
  assign stale_rd = stale;

  // no drive of data while disabled (R1)
  p_dout_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> !dout);

  // standby writes nothing (R2)
  p_standby_nowrite_r2: assert property (@(posedge clk) disable iff (rst)
    !ce |-> !wr_en);

endmodule

// File: tb/dram4k_model_test.sv
module dram4k_model_test;
  localparam int CLK_PERIOD = 10;
  localparam int RETAIN     = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b0;
  logic        cs_n = 1'b1;
  logic        we_n = 1'b1;
  logic [11:0] addr = '0;
  logic        din = 1'b0;
  logic        dout;
  logic        dout_en;
  logic        stale_rd;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram4k_model #(.RETAIN_TICKS(RETAIN)) uut (
    .clk(clk), .rst(rst), .ce(ce), .cs_n(cs_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .stale_rd(stale_rd)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; ce = 1'b0; cs_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  // plain write; address is scrambled after the ce rise (R3)
  task automatic wr(input logic [11:0] a, input logic d);
    @(negedge clk); addr = a; cs_n = 1'b0; we_n = 1'b0; din = d; ce = 1'b1;
    @(negedge clk); addr = ~a;
    @(negedge clk);
    check(dout_en == 1'b0, "R8 write cycle keeps output off", int'(dout_en), 0);
    check(stale_rd == 1'b0, "R11 no stale flag on write", int'(stale_rd), 0);
    ce = 1'b0; we_n = 1'b1;
    @(negedge clk);
  endtask

  // read; din driven opposite to stored bit and toggled (R6)
  task automatic rd(input logic [11:0] a, input logic exp_out, input logic exp_stale,
                    input logic cs_after, input string tag);
    @(negedge clk); addr = a; cs_n = 1'b0; we_n = 1'b1; din = exp_out; ce = 1'b1;
    @(negedge clk); addr = ~a; cs_n = cs_after;
    @(negedge clk);
    check(dout_en == 1'b1, {tag, " R5 output enabled"}, int'(dout_en), 1);
    check(dout == exp_out, {tag, " R7 complement data"}, int'(dout), int'(exp_out));
    check(stale_rd == exp_stale, {tag, " R11 stale flag"}, int'(stale_rd), int'(exp_stale));
    din = ~din;
    @(negedge clk);
    check(dout == exp_out && dout_en, {tag, " R5 data held"}, int'(dout), int'(exp_out));
    check(stale_rd == 1'b0, {tag, " R11 single pulse"}, int'(stale_rd), 0);
    ce = 1'b0; cs_n = 1'b0;
    @(negedge clk);
    check(dout_en == 1'b0 && dout == 1'b0, {tag, " R5 output off after ce low"},
          int'(dout_en), 0);
  endtask

  // deselected access: refresh only (R10, R4)
  task automatic refresh(input logic [11:0] a);
    @(negedge clk); addr = a; cs_n = 1'b1; we_n = 1'b1; ce = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(dout_en == 1'b0, "R4 deselected cycle no output", int'(dout_en), 0);
    check(stale_rd == 1'b0, "R11 no flag when deselected", int'(stale_rd), 0);
    ce = 1'b0; cs_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(dout_en == 0 && dout == 0 && stale_rd == 0, "R1 outputs during reset",
          int'({dout_en, dout, stale_rd}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(dout_en == 0 && dout == 0 && stale_rd == 0, "R1 outputs after reset",
          int'({dout_en, dout, stale_rd}), 0);
  endtask

  task automatic t_basic();
    wr(12'hFFF, 1'b0);
    wr(12'h000, 1'b1);               // scrambled address passes 0xFFF
    wr(12'h5A3, 1'b1);
    rd(12'h000, 1'b0, 1'b0, 1'b0, "R6 cell 000");
    rd(12'hFFF, 1'b1, 1'b0, 1'b0, "R3 cell FFF untouched");
    rd(12'h5A3, 1'b0, 1'b0, 1'b0, "R7 cell 5A3");
    wr(12'h5A3, 1'b0);
    rd(12'h5A3, 1'b1, 1'b0, 1'b0, "R7 cell 5A3 rewritten");
    rd(12'h5A3, 1'b1, 1'b0, 1'b0, "R6 din ignored in read");
  endtask

  task automatic t_standby();
    @(negedge clk); ce = 1'b0; cs_n = 1'b0; we_n = 1'b0; din = 1'b1; addr = 12'h5A3;
    repeat (4) begin
      @(negedge clk);
      check(dout_en == 1'b0, "R2 standby no output", int'(dout_en), 0);
    end
    we_n = 1'b1;
    rd(12'h5A3, 1'b1, 1'b0, 1'b0, "R2 standby did not write");
  endtask

  task automatic t_cs_latch();
    @(negedge clk); addr = 12'h5A3; cs_n = 1'b1; we_n = 1'b0; din = 1'b1; ce = 1'b1;
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk);
    check(dout_en == 1'b0, "R4 late select ignored", int'(dout_en), 0);
    @(negedge clk);
    check(dout_en == 1'b0, "R4 late select ignored still", int'(dout_en), 0);
    ce = 1'b0; we_n = 1'b1;
    @(negedge clk);
    rd(12'h5A3, 1'b1, 1'b0, 1'b0, "R4 deselected write blocked");
    rd(12'h5A3, 1'b1, 1'b0, 1'b1, "R4 late deselect ignored");
  endtask

  task automatic t_rmw();
    wr(12'h2C4, 1'b1);
    @(negedge clk); addr = 12'h2C4; cs_n = 1'b0; we_n = 1'b1; ce = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(dout_en && dout == 1'b0, "R9 rmw read phase", int'(dout), 0);
    we_n = 1'b0; din = 1'b0;
    @(negedge clk);
    check(dout_en && dout == 1'b0, "R9 rmw output held during write", int'(dout), 0);
    we_n = 1'b1;
    @(negedge clk); ce = 1'b0;
    @(negedge clk);
    rd(12'h2C4, 1'b1, 1'b0, 1'b0, "R9 rmw new value");
  endtask

  task automatic t_retention();
    wr(12'h003, 1'b1);
    idle(2 * RETAIN);
    rd(12'h003, 1'b0, 1'b1, 1'b0, "R11 expired row");
    rd(12'h003, 1'b0, 1'b0, 1'b0, "R11 refreshed by read");
    idle(2 * RETAIN);
    wr(12'h003, 1'b0);               // write on expired row: no flag
    rd(12'h003, 1'b1, 1'b0, 1'b0, "R11 fresh after write");
    idle(RETAIN / 2 + 5);
    refresh(12'h0C3);
    idle(RETAIN / 2 + 5);
    rd(12'h003, 1'b1, 1'b0, 1'b0, "R10 deselected refresh");
    idle(2 * RETAIN);
    refresh(12'h003);                // expired and deselected: no flag
  endtask

  task automatic t_rows();
    wr(12'h047, 1'b1);
    wr(12'h088, 1'b0);
    repeat (5) begin
      idle(15);
      refresh(12'h0C7);
    end
    rd(12'h047, 1'b0, 1'b0, 1'b0, "R12 row 7 kept fresh");
    rd(12'h088, 1'b1, 1'b1, 1'b0, "R12 row 8 expired");
  endtask

  task automatic t_reset_ages();
    idle(2 * RETAIN);
    do_reset();
    rd(12'h088, 1'b1, 1'b0, 1'b0, "R13 reset restarts ages, keeps data");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_standby();
    t_cs_latch();
    t_rmw();
    t_retention();
    t_rows();
    t_reset_ages();
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule